// File: doc/BRIEF.md
# Buffered Sample-Clock Edge Counter

This block counts rising edges seen on an asynchronous source pin once software or a sequencer has armed it. A second asynchronous pin acts as a sample clock. On each of its active edges the running count is captured and queued in a small FIFO. The sample clock never clears the counter, so every queued value is the total accumulated since the most recent arm. A consumer drains the queue through a valid/ready stream.

The counting direction comes from a two-bit mode input. The counter can always increment, always decrement, or follow an auxiliary pin: it increments while that pin is high and decrements while it is low. The sample pin may be set to act on its rising edge or on its falling edge. All three pins pass through two-flop synchronizers. Edges are then found in the system clock domain.

Back-pressure rules: `out_valid_o` is high whenever the queue holds at least one value. While `out_valid_o` is high and `out_ready_i` is low, `out_data_o` holds its value. A value leaves the queue on a clock edge where both signals are high. Back-pressure never stalls the counter. When the queue is full, new samples are discarded and recorded in the overflow flag.

Top module: `edge_sample_counter`

## Requirements
- R1: After reset, `out_valid_o` and `overflow_o` are 0, the block is disarmed and the queue is empty.
- R2: A pulse on `arm_i` loads the 32-bit count with zero and enables counting. Source edges that occur while the block is disarmed leave no trace in later samples.
- R3: Each rising edge of `src_i` moves the count by one step once it has passed the two-flop synchronizer. Sampling never resets the count, so queued values are cumulative since the arm.
- R4: `dir_mode_i` selects the direction. 0 counts up, 1 counts down, 2 follows `aux_dir_i` (high counts up, low counts down), and 3 counts up. The count wraps modulo 2^32 in both directions, so one down step from 0 gives 0xFFFFFFFF.
- R5: When `sample_on_fall_i` is 0, each rising edge of `smp_i` pushes the count. When it is 1, each falling edge pushes the count. Edges of the other polarity push nothing.
- R6: If a source edge and a sample edge are detected in the same system cycle, the pushed value already includes that source edge.
- R7: A pulse on `disarm_i` stops both counting and sampling. Values already queued stay readable, and arming again does not flush them.
- R8: The queue holds 16 values. A sample that arrives while the queue is full is dropped and sets `overflow_o`. The flag stays set until the next arm pulse clears it.
- R9: Values leave in the order they were pushed. While `out_valid_o` is high and `out_ready_i` is low, `out_data_o` is held stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm_i | input | 1 | One-cycle pulse: zero the count and start counting |
| disarm_i | input | 1 | One-cycle pulse: stop counting and sampling |
| sample_on_fall_i | input | 1 | 0: sample on rising edge, 1: sample on falling edge |
| dir_mode_i | input | 2 | Direction mode (0 up, 1 down, 2 follow aux, 3 up) |
| src_i | input | 1 | Asynchronous source whose rising edges are counted |
| smp_i | input | 1 | Asynchronous sample clock |
| aux_dir_i | input | 1 | Asynchronous direction pin used in mode 2 |
| out_valid_o | output | 1 | Queue holds a value |
| out_ready_i | input | 1 | Consumer accepts the value at the head of the queue |
| out_data_o | output | 32 | Head of the queue |
| overflow_o | output | 1 | Sticky flag: a sample was dropped because the queue was full |

## Verification
The bench sweeps every direction mode across both sample polarities and both aux levels. Downward counts start from zero, so a counter that saturates instead of wrapping returns 0 where 0xFFFFFFFD is expected. Each run holds the sample pin high across a burst of source edges. A design with the polarity inverted therefore captures the count from before the burst in place of the count after it, or the reverse. The bench applies source and sample edges on the same cycle, which catches a capture path that takes the stale count. It fills the queue past its depth and then checks that the overflow flag is sticky and that the queue kept the first sixteen values in order. It also checks that source edges seen while disarmed, and samples taken after a disarm, never reach the queue.

// File: rtl/esc_pkg.sv
package esc_pkg;
  typedef enum logic [1:0] {
    DIR_UP     = 2'd0,
    DIR_DOWN   = 2'd1,
    DIR_AUX    = 2'd2,
    DIR_UP_ALT = 2'd3
  } dir_mode_e;

  localparam int unsigned CNT_W_DEF = 32;
  localparam int unsigned DEPTH_DEF = 16;
endpackage

// File: rtl/esc_edge_detect.sv
// Two-flop synchronizer per lane plus a history flop for edge detection.
module esc_edge_detect #(
  parameter int unsigned LANES  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] async_i,
  output logic [LANES-1:0] level_o,
  output logic [LANES-1:0] rise_o,
  output logic [LANES-1:0] fall_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync_q <= '0;
        prev_q <= 1'b0;
      end else begin
        sync_q <= {sync_q[STAGES-2:0], async_i[g]};
        prev_q <= sync_q[STAGES-1];
      end
    end

    assign level_o[g] = sync_q[STAGES-1];
    assign rise_o[g]  = sync_q[STAGES-1] & ~prev_q;
    assign fall_o[g]  = ~sync_q[STAGES-1] & prev_q;
  end
endmodule

// File: rtl/esc_counter.sv
// Up/down counter with arm/disarm control and sample capture.
module esc_counter
  import esc_pkg::*;
#(
  parameter int unsigned CNT_W = CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic             disarm_i,
  input  dir_mode_e        mode_i,
  input  logic             aux_lvl_i,
  input  logic             src_edge_i,
  input  logic             smp_edge_i,
  output logic             armed_o,
  output logic             push_o,
  output logic [CNT_W-1:0] push_data_o
);
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_step;
  logic             armed_q;
  logic             step_up;
  logic             live;

  always_comb begin
    unique case (mode_i)
      DIR_DOWN: step_up = 1'b0;
      DIR_AUX:  step_up = aux_lvl_i;
      default:  step_up = 1'b1;
    endcase
  end

  assign count_step = step_up ? count_q + CNT_W'(1) : count_q - CNT_W'(1);
  assign live       = armed_q && !arm_i && !disarm_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      armed_q <= 1'b0;
    end else if (arm_i) begin
      count_q <= '0;
      armed_q <= 1'b1;
    end else if (disarm_i) begin
      armed_q <= 1'b0;
    end else if (armed_q && src_edge_i) begin
      count_q <= count_step;
    end
  end

  assign armed_o     = armed_q;
  assign push_o      = live && smp_edge_i;
  assign push_data_o = src_edge_i ? count_step : count_q;
endmodule

// File: rtl/esc_fifo.sv
// Show-ahead FIFO with valid/ready read side.
module esc_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic             full_o,
  output logic             rd_valid_o,
  input  logic             rd_ready_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic [$clog2(DEPTH):0] level_o
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [AW:0]      level_q;
  logic             do_wr, do_rd;

  assign full_o     = (level_q == (AW+1)'(DEPTH));
  assign rd_valid_o = (level_q != '0);
  assign do_wr      = wr_en_i && !full_o;
  assign do_rd      = rd_valid_o && rd_ready_i;
  assign rd_data_o  = mem_q[rd_ptr_q];
  assign level_o    = level_q;

  always_ff @(posedge clk) begin
    if (do_wr) mem_q[wr_ptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      if (do_wr) wr_ptr_q <= wr_ptr_q + AW'(1);
      if (do_rd) rd_ptr_q <= rd_ptr_q + AW'(1);
      unique case ({do_wr, do_rd})
        2'b10:   level_q <= level_q + (AW+1)'(1);
        2'b01:   level_q <= level_q - (AW+1)'(1);
        default: level_q <= level_q;
      endcase
    end
  end
endmodule

// File: rtl/edge_sample_counter.sv
module edge_sample_counter
  import esc_pkg::*;
#(
  parameter int unsigned CNT_W = CNT_W_DEF,
  parameter int unsigned DEPTH = DEPTH_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic             disarm_i,
  input  logic             sample_on_fall_i,
  input  logic [1:0]       dir_mode_i,
  input  logic             src_i,
  input  logic             smp_i,
  input  logic             aux_dir_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [CNT_W-1:0] out_data_o,
  output logic             overflow_o
);
  localparam int unsigned LW = $clog2(DEPTH) + 1;
  localparam int unsigned L_SRC = 0, L_SMP = 1, L_AUX = 2;

  logic [2:0]       lvl, rise, fall;
  logic             smp_edge, armed, push, full, ovf_q;
  logic [CNT_W-1:0] push_data;
  logic [LW-1:0]    level;

  esc_edge_detect #(.LANES(3), .STAGES(2)) u_edges (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({aux_dir_i, smp_i, src_i}),
    .level_o (lvl),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  assign smp_edge = sample_on_fall_i ? fall[L_SMP] : rise[L_SMP];

  esc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .arm_i       (arm_i),
    .disarm_i    (disarm_i),
    .mode_i      (dir_mode_e'(dir_mode_i)),
    .aux_lvl_i   (lvl[L_AUX]),
    .src_edge_i  (rise[L_SRC]),
    .smp_edge_i  (smp_edge),
    .armed_o     (armed),
    .push_o      (push),
    .push_data_o (push_data)
  );

  esc_fifo #(.WIDTH(CNT_W), .DEPTH(DEPTH)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (push),
    .wr_data_i  (push_data),
    .full_o     (full),
    .rd_valid_o (out_valid_o),
    .rd_ready_i (out_ready_i),
    .rd_data_o  (out_data_o),
    .level_o    (level)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            ovf_q <= 1'b0;
    else if (arm_i)        ovf_q <= 1'b0;
    else if (push && full) ovf_q <= 1'b1;
  end

  assign overflow_o = ovf_q;
endmodule

// File: rtl/esc_checker.sv
module esc_checker #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned LW    = 5,
  parameter int unsigned DEPTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             arm_i,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [CNT_W-1:0] out_data_o,
  input logic             overflow_o,
  input logic             armed,
  input logic             push,
  input logic [LW-1:0]    level
);
  // R8: the overflow flag holds until an arm pulse
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o && !arm_i |=> overflow_o);
  // R8: an arm pulse clears the overflow flag
  a_r8_arm_clears: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |=> !overflow_o);
  // R9: the head value is held under back-pressure
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));
  // R7: nothing is pushed while disarmed
  a_r7_no_push_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !push);
  // R8: the level never exceeds the depth
  a_r8_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));
  // R2: an arm pulse leaves the block armed
  a_r2_armed_after_arm: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |=> armed);
endmodule

bind edge_sample_counter esc_checker #(.CNT_W(CNT_W), .LW(LW), .DEPTH(DEPTH)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .arm_i       (arm_i),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o),
  .overflow_o  (overflow_o),
  .armed       (armed),
  .push        (push),
  .level       (level)
);

// File: tb/edge_sample_counter_tb_top.sv
`timescale 1ns/1ps
module edge_sample_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arm_i = 1'b0, disarm_i = 1'b0, sample_on_fall_i = 1'b0;
  logic [1:0]  dir_mode_i = 2'd0;
  logic        src_i = 1'b0, smp_i = 1'b0, aux_dir_i = 1'b0;
  logic        out_valid_o, out_ready_i = 1'b0, overflow_o;
  logic [31:0] out_data_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  edge_sample_counter dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_arm();
    @(negedge clk); arm_i = 1'b1;
    @(negedge clk); arm_i = 1'b0;
    wait_cyc(2);
  endtask

  task automatic pulse_disarm();
    @(negedge clk); disarm_i = 1'b1;
    @(negedge clk); disarm_i = 1'b0;
    wait_cyc(2);
  endtask

  task automatic src_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      src_i = 1'b1; wait_cyc(3);
      src_i = 1'b0; wait_cyc(3);
    end
  endtask

  task automatic smp_pulse();
    smp_i = 1'b1; wait_cyc(4);
    smp_i = 1'b0; wait_cyc(4);
  endtask

  task automatic read_one(input string req, input logic [31:0] exp);
    int waited = 0;
    while (!out_valid_o && waited < 50) begin
      @(negedge clk); waited++;
    end
    chk(req, {31'd0, out_valid_o}, 32'd1);
    chk(req, out_data_o, exp);
    out_ready_i = 1'b1;
    @(negedge clk);
    out_ready_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] exp_v, step;
    wait_cyc(3);
    chk("R1 valid", {31'd0, out_valid_o}, 32'd0);
    chk("R1 ovf", {31'd0, overflow_o}, 32'd0);
    rst_n = 1'b1;
    wait_cyc(2);
    chk("R1 valid after reset", {31'd0, out_valid_o}, 32'd0);

    // R2 R3 R4 R5 sweep: mode x polarity x aux
    for (int m = 0; m < 4; m++) begin
      for (int p = 0; p < 2; p++) begin
        for (int a = 0; a < 2; a++) begin
          pulse_disarm();
          dir_mode_i = 2'(m); sample_on_fall_i = p[0]; aux_dir_i = a[0];
          src_pulses(2);               // R2: ignored while disarmed
          wait_cyc(4);
          pulse_arm();
          step = (m == 1 || (m == 2 && a == 0)) ? 32'hFFFF_FFFF : 32'd1;
          src_pulses(m + 1);
          smp_pulse();
          exp_v = step * 32'(m + 1);
          smp_i = 1'b1; wait_cyc(4);
          src_pulses(2);
          smp_i = 1'b0; wait_cyc(6);
          read_one("R2 R4 first sample", exp_v);
          read_one("R3 R5 second sample", (p == 1) ? exp_v + step * 32'd2 : exp_v);
          chk("R5 no extra push", {31'd0, out_valid_o}, 32'd0);
        end
      end
    end

    // R6: source and sample edges in the same cycle
    pulse_disarm();
    dir_mode_i = 2'd0; sample_on_fall_i = 1'b0;
    pulse_arm();
    src_pulses(3);
    @(negedge clk); src_i = 1'b1; smp_i = 1'b1;
    wait_cyc(4); src_i = 1'b0; smp_i = 1'b0; wait_cyc(6);
    read_one("R6 same-cycle include", 32'd4);

    // R7: disarm stops sampling, queued data stays, re-arm keeps it
    src_pulses(1);
    smp_pulse();                      // 5 queued
    pulse_disarm();
    src_pulses(2);
    smp_pulse();
    wait_cyc(4);
    pulse_arm();
    read_one("R7 survives disarm and arm", 32'd5);
    chk("R7 no sample while disarmed", {31'd0, out_valid_o}, 32'd0);

    // R8 R9: overflow
    pulse_arm();
    for (int i = 0; i < 18; i++) begin
      src_pulses(1);
      smp_pulse();
    end
    wait_cyc(4);
    chk("R8 overflow set", {31'd0, overflow_o}, 32'd1);
    exp_v = out_data_o;
    wait_cyc(5);
    chk("R9 head held under back-pressure", out_data_o, exp_v);
    for (int i = 0; i < 16; i++) read_one("R9 R8 in-order kept", 32'(i + 1));
    chk("R8 dropped values absent", {31'd0, out_valid_o}, 32'd0);
    chk("R8 flag still set", {31'd0, overflow_o}, 32'd1);
    pulse_arm();
    chk("R8 arm clears flag", {31'd0, overflow_o}, 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule